// File: doc/BRIEF.md
# Stack Pointer and Exception Unit

This block keeps the stack pointer of a 16-bit, word-addressed processor whose data space holds 2^20 words. In each cycle it is given the stack operation of the current instruction. From that it produces, without a clock edge, the data address the stack access uses and the value the stack pointer takes next. Two kinds of stack step are handled. Single-word steps (push, pop) move the pointer by one. Double-word steps carry a return address: subroutine call and software interrupt move the pointer down by two, and return and return-from-interrupt move it up by two.

The block also detects two faults. One is a stack read that would pass the top of memory. The other is a data access whose address lies above 0xFF00. When a fault occurs, the stack pointer keeps its value. In the next cycle the block raises a one-cycle exception strobe with a cause code, captures the faulting instruction's address in an exception PC, and gives the instruction-memory word that holds the first half of the handler address. A software interrupt gives its vector word in the same way, but without the exception strobe. Fetching the handler words, flushing the pipeline and accessing memory are left to the surrounding logic.

Top module: `stack_exc_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, sp is 0xFFFFF, exc_strobe is 0, vec_valid is 0, exc_cause is 0 and epc is 0.
- R2: A stack step is active only when op_valid is 1. The op codes are 0 none, 1 push, 2 pop, 3 call, 4 return, 5 interrupt and 6 return-from-interrupt. With op_valid at 0, sp does not change.
- R3: For a push, stack_addr equals sp, sp_next equals sp−1, and sp takes that value at the clock edge.
- R4: For a pop, stack_addr and sp_next both equal sp+1, and sp takes that value at the clock edge.
- R5: For a call or an interrupt, stack_addr equals sp and sp_next equals sp−2. The two return-address words go at sp and sp−1.
- R6: For a return or a return-from-interrupt, stack_addr and sp_next both equal sp+2.
- R7: An empty-stack fault occurs on a pop with sp = 0xFFFFF, or on a return or return-from-interrupt with sp above 0xFFFFD. In the next cycle exc_strobe is 1, exc_cause is 01, vec_valid is 1 and vec_addr is 2. sp keeps its value.
- R8: An invalid-address fault occurs when mem_req is 1 and mem_addr is greater than 0xFF00. The address 0xFF00 itself is allowed. In the next cycle exc_strobe is 1, exc_cause is 10, vec_valid is 1 and vec_addr is 4. sp keeps its value, even if a stack step was requested.
- R9: In the cycle after any fault, epc holds the instr_pc of the faulting cycle. In all other cases epc keeps its value.
- R10: If both faults occur in the same cycle, only the empty-stack fault is reported, with cause 01 and vector 2.
- R11: An interrupt without a fault gives vec_valid 1 and exc_strobe 0 in the next cycle. vec_addr is 6 when int_sel is 0 (index 0) and 8 when int_sel is 1 (index 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A stack step is requested this cycle |
| op | input | 3 | Stack step code |
| int_sel | input | 1 | Interrupt index select: 0 for index 0, 1 for index 2 |
| mem_req | input | 1 | A data load or store is issued this cycle |
| mem_addr | input | AW | Address of that data access |
| instr_pc | input | PCW | Address of the instruction in this stage |
| sp | output | AW | Current stack pointer |
| stack_addr | output | AW | Data address of this cycle's stack access |
| sp_next | output | AW | Stack pointer value after this cycle |
| exc_strobe | output | 1 | One-cycle exception pulse |
| exc_cause | output | 2 | 01 empty stack, 10 invalid address |
| vec_valid | output | 1 | vec_addr is meaningful |
| vec_addr | output | IAW | Instruction word holding the first half of the handler address |
| epc | output | PCW | Captured address of the faulting instruction |

## Verification
The bench targets the edges of the empty test. A pop at the top address must fault, while a pop one word below it must not. A double-word return must fault one word below the top, where an off-by-one bound would let it through and wrap the pointer. It also probes the address limit at 0xFF00 and 0xFF01. A `>=` comparison would fault on the legal word, and a missing comparison would let a stray access through. A fault raised together with a push must leave the pointer unchanged, and when both faults occur at once the empty-stack cause must win. Interrupts must select vector word 6 or 8 and must not raise the exception strobe. An off-by-one in the slot arithmetic, or a strobe tied to every vector, would show up there.

// File: rtl/stack_exc_unit.sv
module stack_exc_unit #(
  parameter int AW  = 20,
  parameter int IAW = 20,
  parameter int PCW = 32,
  parameter logic [AW-1:0] ADDR_LIMIT = AW'(20'h0FF00)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [2:0]     op,
  input  logic           int_sel,
  input  logic           mem_req,
  input  logic [AW-1:0]  mem_addr,
  input  logic [PCW-1:0] instr_pc,
  output logic [AW-1:0]  sp,
  output logic [AW-1:0]  stack_addr,
  output logic [AW-1:0]  sp_next,
  output logic           exc_strobe,
  output logic [1:0]     exc_cause,
  output logic           vec_valid,
  output logic [IAW-1:0] vec_addr,
  output logic [PCW-1:0] epc
);

  localparam logic [AW-1:0]  TOP       = {AW{1'b1}};
  localparam logic [AW-1:0]  ONE       = AW'(1);
  localparam logic [AW-1:0]  TWO       = AW'(2);
  localparam logic [AW-1:0]  DBL_LIMIT = TOP - TWO;
  localparam logic [IAW-1:0] VEC_EMPTY = IAW'(2);
  localparam logic [IAW-1:0] VEC_BAD   = IAW'(4);
  localparam logic [IAW-1:0] VEC_INT   = IAW'(6);

  logic is_push, is_pop, is_call, is_ret, is_int, is_rti;
  logic down2, up2, empty_hit, bad_hit, exc_any;
  logic [AW-1:0] stepped;

  assign is_push = op_valid && (op == 3'd1);
  assign is_pop  = op_valid && (op == 3'd2);
  assign is_call = op_valid && (op == 3'd3);
  assign is_ret  = op_valid && (op == 3'd4);
  assign is_int  = op_valid && (op == 3'd5);
  assign is_rti  = op_valid && (op == 3'd6);
  assign down2   = is_call || is_int;
  assign up2     = is_ret || is_rti;

  assign empty_hit = (is_pop && (sp == TOP)) || (up2 && (sp > DBL_LIMIT));
  assign bad_hit   = mem_req && (mem_addr > ADDR_LIMIT);
  assign exc_any   = empty_hit || bad_hit;

  always_comb begin
    stepped    = sp;
    stack_addr = sp;
    if (is_push) begin
      stepped = sp - ONE;
    end else if (is_pop) begin
      stepped    = sp + ONE;
      stack_addr = sp + ONE;
    end else if (down2) begin
      stepped = sp - TWO;
    end else if (up2) begin
      stepped    = sp + TWO;
      stack_addr = sp + TWO;
    end
  end

  assign sp_next = exc_any ? sp : stepped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp         <= TOP;
      exc_strobe <= 1'b0;
      exc_cause  <= 2'b00;
      vec_valid  <= 1'b0;
      vec_addr   <= '0;
      epc        <= '0;
    end else begin
      sp         <= sp_next;
      exc_strobe <= exc_any;
      vec_valid  <= exc_any || is_int;
      if (empty_hit) begin
        exc_cause <= 2'b01;
        vec_addr  <= VEC_EMPTY;
      end else if (bad_hit) begin
        exc_cause <= 2'b10;
        vec_addr  <= VEC_BAD;
      end else begin
        exc_cause <= 2'b00;
        vec_addr  <= int_sel ? (VEC_INT + IAW'(2)) : VEC_INT;
      end
      if (exc_any) epc <= instr_pc;
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !mem_req) |=> (sp == $past(sp)));

  p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_push && !bad_hit) |=> (sp == $past(sp) - ONE));

  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pop && !exc_any) |=> (sp == $past(sp) + ONE));

  p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pop && (sp == TOP)) |=> (exc_strobe && exc_cause == 2'b01 && vec_addr == VEC_EMPTY && $stable(sp)));

  p_bad_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_hit && !empty_hit) |=> (exc_strobe && exc_cause == 2'b10 && vec_addr == VEC_BAD));

  p_epc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_any |=> (epc == $past(instr_pc)));

  p_epc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_any |=> $stable(epc));

  p_one_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe |-> ($countones(exc_cause) == 1));

  p_int_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_int && !exc_any) |=> (vec_valid && !exc_strobe));

endmodule

// File: tb/stack_exc_unit_tb.sv
`timescale 1ns/1ps
module stack_exc_unit_tb;
  localparam int AW = 20, IAW = 20, PCW = 32;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, int_sel = 0, mem_req = 0;
  logic [2:0] op = 0;
  logic [AW-1:0] mem_addr = 0;
  logic [PCW-1:0] instr_pc = 0;
  logic [AW-1:0] sp, stack_addr, sp_next;
  logic exc_strobe, vec_valid;
  logic [1:0] exc_cause;
  logic [IAW-1:0] vec_addr;
  logic [PCW-1:0] epc;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  stack_exc_unit #(.AW(AW), .IAW(IAW), .PCW(PCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .int_sel(int_sel),
    .mem_req(mem_req), .mem_addr(mem_addr), .instr_pc(instr_pc),
    .sp(sp), .stack_addr(stack_addr), .sp_next(sp_next),
    .exc_strobe(exc_strobe), .exc_cause(exc_cause), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .epc(epc));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [2:0] o, logic is, logic mr, logic [AW-1:0] ma, logic [PCW-1:0] pc);
    op_valid = v; op = o; int_sel = is; mem_req = mr; mem_addr = ma; instr_pc = pc;
    #1;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    op_valid = 0; op = 0; mem_req = 0; int_sel = 0; mem_addr = 0;
    #1;
  endtask

  task automatic t_reset();
    check("R1 sp", 32'(sp), 32'(TOP));
    check("R1 strobe", 32'(exc_strobe), 0);
    check("R1 vec_valid", 32'(vec_valid), 0);
    check("R1 cause", 32'(exc_cause), 0);
    check("R1 epc", epc, 0);
  endtask

  task automatic t_empty_pop();
    drive(1, 3'd2, 0, 0, 0, 32'h100);
    check("R7 pop sp_next", 32'(sp_next), 32'(TOP));
    tick();
    check("R7 strobe", 32'(exc_strobe), 1);
    check("R7 cause", 32'(exc_cause), 1);
    check("R7 vec", 32'(vec_addr), 2);
    check("R7 vec_valid", 32'(vec_valid), 1);
    check("R7 sp", 32'(sp), 32'(TOP));
    check("R9 epc", epc, 32'h100);
  endtask

  task automatic t_push_pop();
    drive(1, 3'd1, 0, 0, 0, 32'h101);
    check("R3 addr", 32'(stack_addr), 32'(TOP));
    check("R3 next", 32'(sp_next), 32'(TOP - 1));
    tick();
    check("R3 sp", 32'(sp), 32'(TOP - 1));
    check("R3 strobe", 32'(exc_strobe), 0);
    check("R9 epc hold", epc, 32'h100);
    drive(0, 3'd1, 0, 0, 0, 32'h102);
    tick();
    check("R2 idle", 32'(sp), 32'(TOP - 1));
    drive(1, 3'd0, 0, 0, 0, 32'h103);
    tick();
    check("R2 none", 32'(sp), 32'(TOP - 1));
    drive(1, 3'd2, 0, 0, 0, 32'h104);
    check("R4 addr", 32'(stack_addr), 32'(TOP));
    check("R4 next", 32'(sp_next), 32'(TOP));
    tick();
    check("R4 sp", 32'(sp), 32'(TOP));
    check("R4 no strobe", 32'(exc_strobe), 0);
  endtask

  task automatic t_call_ret();
    drive(1, 3'd3, 0, 0, 0, 32'h200);
    check("R5 addr", 32'(stack_addr), 32'(TOP));
    check("R5 next", 32'(sp_next), 32'(TOP - 2));
    tick();
    check("R5 sp", 32'(sp), 32'(TOP - 2));
    drive(1, 3'd4, 0, 0, 0, 32'h201);
    check("R6 addr", 32'(stack_addr), 32'(TOP));
    check("R6 next", 32'(sp_next), 32'(TOP));
    tick();
    check("R6 sp", 32'(sp), 32'(TOP));
    check("R6 no strobe", 32'(exc_strobe), 0);
    drive(1, 3'd4, 0, 0, 0, 32'h202);
    tick();
    check("R7 ret top", 32'(exc_cause), 1);
    check("R7 ret sp", 32'(sp), 32'(TOP));
    drive(1, 3'd1, 0, 0, 0, 32'h203);
    tick();
    drive(1, 3'd6, 0, 0, 0, 32'h204);
    tick();
    check("R7 rti top-1 strobe", 32'(exc_strobe), 1);
    check("R7 rti top-1 sp", 32'(sp), 32'(TOP - 1));
    check("R9 rti epc", epc, 32'h204);
    drive(1, 3'd1, 0, 0, 0, 32'h205);
    tick();
    drive(1, 3'd2, 0, 0, 0, 32'h206);
    tick();
    check("R4 pop below top ok", 32'(exc_strobe), 0);
    check("R4 pop below top sp", 32'(sp), 32'(TOP - 1));
    drive(1, 3'd2, 0, 0, 0, 32'h207);
    tick();
  endtask

  task automatic t_bad_addr();
    drive(0, 3'd0, 0, 1, 20'h0FF00, 32'h300);
    tick();
    check("R8 limit ok", 32'(exc_strobe), 0);
    check("R8 limit epc", epc, 32'h204);
    drive(0, 3'd0, 0, 1, 20'h0FF01, 32'h301);
    tick();
    check("R8 strobe", 32'(exc_strobe), 1);
    check("R8 cause", 32'(exc_cause), 2);
    check("R8 vec", 32'(vec_addr), 4);
    check("R9 epc bad", epc, 32'h301);
    drive(1, 3'd1, 0, 1, 20'hFFFF0, 32'h302);
    check("R8 push next", 32'(sp_next), 32'(TOP));
    tick();
    check("R8 push held", 32'(sp), 32'(TOP));
    check("R8 push cause", 32'(exc_cause), 2);
  endtask

  task automatic t_priority();
    drive(1, 3'd2, 0, 1, 20'h10000, 32'h400);
    tick();
    check("R10 strobe", 32'(exc_strobe), 1);
    check("R10 cause", 32'(exc_cause), 1);
    check("R10 vec", 32'(vec_addr), 2);
    tick();
    check("R10 single pulse", 32'(exc_strobe), 0);
  endtask

  task automatic t_int();
    drive(1, 3'd5, 0, 0, 0, 32'h500);
    check("R5 int next", 32'(sp_next), 32'(TOP - 2));
    tick();
    check("R11 vec_valid", 32'(vec_valid), 1);
    check("R11 no strobe", 32'(exc_strobe), 0);
    check("R11 vec idx0", 32'(vec_addr), 6);
    check("R11 epc hold", epc, 32'h400);
    drive(1, 3'd5, 1, 0, 0, 32'h501);
    tick();
    check("R11 vec idx2", 32'(vec_addr), 8);
    check("R5 int sp", 32'(sp), 32'(TOP - 4));
    drive(1, 3'd6, 0, 0, 0, 32'h502);
    tick();
    drive(1, 3'd6, 0, 0, 0, 32'h503);
    tick();
    check("R6 rti sp", 32'(sp), 32'(TOP));
    check("R6 rti no vec", 32'(vec_valid), 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_empty_pop();
    t_push_pop();
    t_call_ret();
    t_bad_addr();
    t_priority();
    t_int();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule